// File: doc/BRIEF.md
# Preloadable 8-bit Timer/Event Counter with Frequency Output

This block is an up-counter with a separate reload register and three ways of advancing. It can count active edges on an external input. It can count ticks of an internal reference divided by a programmable prescaler. It can also measure how long the external input stays at its active level, counted in prescaled ticks. The internal reference is either the system clock or a slower real-time tick. A parameter fixes that choice, and the real-time tick arrives as a one-cycle strobe in the system clock domain.

Software programs a reload value through the data port and reads the live count back through the same port. It sets mode, enable, active edge and prescale through the control port. Each time the count wraps past its maximum, the counter restarts from the reload value, a sticky interrupt flag is raised, and a square-wave output toggles. The square wave therefore runs at fINT/(2·(256−N)), where N is the reload value. The external input is synchronised with two flops before any edge is taken from it.

Top module: `evt_timer8`

## Requirements
- R1: After reset the live count, the control read-back, the interrupt flag and the square-wave output are all zero.
- R2: A data write changes only the reload register: the live count read on the data port is unchanged by it.
- R3: The control read-back returns prescale in bits [2:0], active-edge select in bit 3, enable in bit 4 and mode in bits [7:6], as last written. Bit 5 always reads 0.
- R4: In timer mode (mode 10), the count rises by one for every 2^(psc+1) reference ticks. The reference is every system clock cycle when USE_RTC=0, or each rtc_tick strobe when USE_RTC=1.
- R5: In event mode (mode 01), the count rises by one for each active edge of ext_in: rising when bit 3 is 0, falling when bit 3 is 1. The inactive edge has no effect.
- R6: An increment from all-ones loads the reload value and sets irq_flag. irq_flag stays set until irq_clr is asserted, and a wrap in the same cycle wins over irq_clr.
- R7: pfd_out toggles on every wrap, so with reload N and prescale p in timer mode each half period lasts (256−N)·2^(psc+1) system cycles.
- R8: With the enable bit at 0, or with mode 00, the count holds its value.
- R9: In pulse-width mode (mode 11), no counting happens until an active edge. From that edge on, prescaled ticks are counted while the input stays at its active level. On the opposite edge counting stops and hardware clears the enable bit.
- R10: The prescaler restarts whenever counting is not running, so the first increment after enabling timer mode comes a full 2^(psc+1) ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle strobe of the real-time reference (used when USE_RTC=1) |
| ext_in | input | 1 | External event / pulse input, asynchronous |
| data_we | input | 1 | Write strobe for the reload register |
| data_wdata | input | CNT_W | Reload value |
| data_rdata | output | CNT_W | Live count |
| ctrl_we | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control value (layout as in R3) |
| ctrl_rdata | output | 8 | Control read-back |
| irq_clr | input | 1 | Clears the sticky interrupt flag |
| irq_flag | output | 1 | Sticky wrap flag |
| pfd_out | output | 1 | Square wave that toggles on each wrap |

## Verification
A prescaler phase that is off by one shows up on data_rdata within one prescale period after enabling, as an early or late first increment. A wrong reload path shows up on the cycle after the first wrap, as a count other than N. Edge-detect or level errors in the synchroniser appear a few cycles after the input toggles, as a count that moved on the wrong edge. In pulse-width mode they also appear as an enable bit that never drops. The square-wave half periods are measured cycle-exactly across several reload and prescale pairs, so a miscount in the wrap logic changes a measured interval at once.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'b00,
      MODE_EVENT = 2'b01,
      MODE_TIMER = 2'b10,
      MODE_PULSE = 2'b11
   } tmr_mode_e;

   localparam int CTRL_W      = 8;
   localparam int PSC_FIELD_W = 3;
   localparam int BIT_EDGE    = 3;
   localparam int BIT_ON      = 4;
   localparam int BIT_GAP     = 5;
   localparam int BIT_MODE_LO = 6;

endpackage

// File: rtl/evt_input_sync.sv
module evt_input_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic edge_fall,
   output logic lvl_active,
   output logic edge_active,
   output logic edge_inactive
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evt_input_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-1:0], pin};
   end

   logic cur_lvl, prev_lvl;
   assign cur_lvl       = chain_q[STAGES-1] ^ edge_fall;
   assign prev_lvl      = chain_q[STAGES]   ^ edge_fall;
   assign lvl_active    = cur_lvl;
   assign edge_active   = cur_lvl & ~prev_lvl;
   assign edge_inactive = ~cur_lvl & prev_lvl;

endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
   parameter int PSC_W   = 3,
   parameter int USE_RTC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rtc_tick,
   input  logic [PSC_W-1:0] sel,
   output logic             tick
);
   localparam int DIV_W = 1 << PSC_W;

   generate
      if (PSC_W < 1 || PSC_W > 3) begin : g_bad_psc
         $error("evt_prescaler: PSC_W must be 1..3");
      end
      if (USE_RTC != 0 && USE_RTC != 1) begin : g_bad_rtc
         $error("evt_prescaler: USE_RTC must be 0 or 1");
      end
   endgenerate

   logic base;
   generate
      if (USE_RTC == 1) begin : g_base_rtc
         assign base = rtc_tick;
      end else begin : g_base_sys
         assign base = 1'b1;
      end
   endgenerate

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   always_comb begin
      for (int i = 0; i < DIV_W; i++) begin
         mask[i] = (i <= int'(sel));
      end
   end

   assign tick = run && base && ((div_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (!run)   div_q <= '0;
      else if (base)   div_q <= div_q + 1'b1;
   end

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap  = inc && (cnt_q == '1);
   assign count = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (wrap)  cnt_q <= reload;
      else if (inc)   cnt_q <= cnt_q + 1'b1;
   end

endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
   import evt_timer8_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PSC_W       = 3,
   parameter int SYNC_STAGES = 2,
   parameter int USE_RTC     = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rtc_tick,
   input  logic             ext_in,
   input  logic             data_we,
   input  logic [CNT_W-1:0] data_wdata,
   output logic [CNT_W-1:0] data_rdata,
   input  logic             ctrl_we,
   input  logic [7:0]       ctrl_wdata,
   output logic [7:0]       ctrl_rdata,
   input  logic             irq_clr,
   output logic             irq_flag,
   output logic             pfd_out
);
   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
         $error("evt_timer8: CNT_W must be 2..16");
      end
      if (PSC_W > PSC_FIELD_W) begin : g_bad_field
         $error("evt_timer8: PSC_W does not fit the control field");
      end
   endgenerate

   // control state
   logic [PSC_W-1:0] psc_q;
   logic             edge_fall_q;
   logic             on_q;
   tmr_mode_e        mode_q;

   // synchronised input
   logic lvl_act, edge_act, edge_inact;

   evt_input_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk           (clk),
      .rst_n         (rst_n),
      .pin           (ext_in),
      .edge_fall     (edge_fall_q),
      .lvl_active    (lvl_act),
      .edge_active   (edge_act),
      .edge_inactive (edge_inact)
   );

   // pulse-width window
   logic pw_mode, pw_open_q, pw_stop;
   assign pw_mode = on_q && (mode_q == MODE_PULSE);
   assign pw_stop = pw_mode && pw_open_q && edge_inact;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pw_open_q <= 1'b0;
      else if (!pw_mode)    pw_open_q <= 1'b0;
      else if (edge_act)    pw_open_q <= 1'b1;
      else if (edge_inact)  pw_open_q <= 1'b0;
   end

   // prescaler
   logic psc_run, psc_tick;
   assign psc_run = on_q && ((mode_q == MODE_TIMER) || (pw_mode && pw_open_q));

   evt_prescaler #(.PSC_W(PSC_W), .USE_RTC(USE_RTC)) u_psc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (psc_run),
      .rtc_tick (rtc_tick),
      .sel      (psc_q),
      .tick     (psc_tick)
   );

   // control register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         psc_q       <= '0;
         edge_fall_q <= 1'b0;
         on_q        <= 1'b0;
         mode_q      <= MODE_OFF;
      end else if (ctrl_we) begin
         psc_q       <= ctrl_wdata[PSC_W-1:0];
         edge_fall_q <= ctrl_wdata[BIT_EDGE];
         on_q        <= ctrl_wdata[BIT_ON];
         mode_q      <= tmr_mode_e'(ctrl_wdata[BIT_MODE_LO +: 2]);
      end else if (pw_stop) begin
         on_q        <= 1'b0;
      end
   end

   logic [PSC_FIELD_W-1:0] psc_field;
   assign psc_field  = PSC_FIELD_W'(psc_q);
   assign ctrl_rdata = {mode_q, 1'b0, on_q, edge_fall_q, psc_field};

   // reload register
   logic [CNT_W-1:0] reload_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        reload_q <= '0;
      else if (data_we)  reload_q <= data_wdata;
   end

   // counter
   logic cnt_inc, cnt_wrap;
   assign cnt_inc = on_q && (((mode_q == MODE_EVENT) && edge_act) || (psc_run && psc_tick));

   evt_count_core #(.CNT_W(CNT_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (cnt_inc),
      .reload (reload_q),
      .count  (data_rdata),
      .wrap   (cnt_wrap)
   );

   // wrap outputs
   logic irq_q, pfd_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         pfd_q <= 1'b0;
      end else begin
         if (cnt_wrap)     irq_q <= 1'b1;
         else if (irq_clr) irq_q <= 1'b0;
         if (cnt_wrap)     pfd_q <= ~pfd_q;
      end
   end

   assign irq_flag = irq_q;
   assign pfd_out  = pfd_q;

endmodule

// File: rtl/evt_timer8_chk.sv
module evt_timer8_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_we,
   input logic [CNT_W-1:0] data_rdata,
   input logic [7:0]       ctrl_rdata,
   input logic             irq_clr,
   input logic             irq_flag,
   input logic             pfd_out
);
   // R3: the unused control bit never reads as 1
   p_gap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rdata[5] == 1'b0);

   // R8: disabled or mode 00 keeps the count frozen
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_rdata[4] || ctrl_rdata[7:6] == 2'b00) |=> data_rdata == $past(data_rdata));

   // R4: below all-ones the count only holds or steps by one
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rdata != '1) |=> (data_rdata == $past(data_rdata) ||
                              data_rdata == $past(data_rdata) + 1'b1));

   // R6: leaving all-ones means a wrap, which raises the flag
   p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rdata == '1) ##1 (data_rdata != '1) |-> irq_flag);

   // R6: the flag is sticky until cleared
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag && !irq_clr) |=> irq_flag);

   // R7: a fresh flag comes with a square-wave toggle
   p_pfd_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flag) |-> pfd_out != $past(pfd_out));

   // R9: hardware only drops the enable bit in pulse-width mode
   p_pw_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ctrl_rdata[4]) && !$past(ctrl_we)) |-> ctrl_rdata[7:6] == 2'b11);

endmodule

bind evt_timer8 evt_timer8_chk #(.CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctrl_we    (ctrl_we),
   .data_rdata (data_rdata),
   .ctrl_rdata (ctrl_rdata),
   .irq_clr    (irq_clr),
   .irq_flag   (irq_flag),
   .pfd_out    (pfd_out)
);

// File: tb/evt_timer8_bench.sv
`timescale 1ns/1ps
module evt_timer8_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rtc_tick = 1'b0;
   logic       ext_in = 1'b0;
   logic       data_we = 1'b0;
   logic [7:0] data_wdata = '0;
   logic [7:0] data_rdata;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wdata = '0;
   logic [7:0] ctrl_rdata;
   logic       irq_clr = 1'b0;
   logic       irq_flag, pfd_out;
   logic [7:0] r_data, r_ctrl;
   logic       r_irq, r_pfd;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   evt_timer8 u_evt_timer8 (
      .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .ext_in(ext_in),
      .data_we(data_we), .data_wdata(data_wdata), .data_rdata(data_rdata),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
      .irq_clr(irq_clr), .irq_flag(irq_flag), .pfd_out(pfd_out));

   evt_timer8 #(.USE_RTC(1)) u_evt_timer8_rtc (
      .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .ext_in(ext_in),
      .data_we(data_we), .data_wdata(data_wdata), .data_rdata(r_data),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(r_ctrl),
      .irq_clr(irq_clr), .irq_flag(r_irq), .pfd_out(r_pfd));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_wdata = v; ctrl_we = 1'b1; step(1); ctrl_we = 1'b0;
   endtask

   task automatic wr_data(input logic [7:0] v);
      data_wdata = v; data_we = 1'b1; step(1); data_we = 1'b0;
   endtask

   function automatic logic [7:0] ctl(input int mode, input bit on, input bit fall, input int psc);
      return {2'(mode), 1'b0, on, fall, 3'(psc)};
   endfunction

   task automatic wait_pfd(output int n);
      logic prev;
      prev = pfd_out;
      n = 0;
      while (pfd_out == prev && n < 5000) begin
         step(1);
         n++;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   endtask

   initial begin
      #1_500_000;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int c0, c1, r0, n;
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      chk("R1 count", data_rdata, 0);
      chk("R1 ctrl", ctrl_rdata, 0);
      chk("R1 irq", irq_flag, 0);
      chk("R1 pfd", pfd_out, 0);

      // R3 control read-back, bit 5 forced to zero
      wr_ctrl(8'hFF);
      chk("R3 all ones", ctrl_rdata, 8'hDF);
      wr_ctrl(8'h2A);
      chk("R3 pattern", ctrl_rdata, 8'h0A);
      wr_ctrl(ctl(2, 0, 1, 5));
      chk("R3 fields", ctrl_rdata, 8'h8D);

      // R4 timer mode, every prescale setting
      for (int p = 0; p < 8; p++) begin
         int k;
         wr_ctrl(ctl(2, 0, 0, p));
         step(1);
         c0 = data_rdata;
         wr_ctrl(ctl(2, 1, 0, p));
         k = (3 << (p + 1)) + 1;
         step(k);
         chk($sformatf("R4 psc %0d", p), data_rdata, (c0 + 3) & 8'hFF);
      end

      // R10 prescaler restart
      wr_ctrl(ctl(2, 0, 0, 2));
      c0 = data_rdata;
      wr_ctrl(ctl(2, 1, 0, 2));
      step(5);
      wr_ctrl(ctl(2, 0, 0, 2));
      wr_ctrl(ctl(2, 1, 0, 2));
      step(7);
      chk("R10 before full period", data_rdata, c0);
      step(1);
      chk("R10 after full period", data_rdata, (c0 + 1) & 8'hFF);

      // R8 hold when off or mode 00
      wr_ctrl(ctl(0, 1, 0, 0));
      c0 = data_rdata;
      step(40);
      chk("R8 mode 00", data_rdata, c0);
      wr_ctrl(ctl(2, 0, 0, 0));
      step(40);
      chk("R8 disabled", data_rdata, c0);

      // R4 real-time reference on the second instance
      r0 = r_data;
      wr_ctrl(ctl(2, 1, 0, 0));
      for (int i = 0; i < 6; i++) begin
         rtc_tick = 1'b1; step(1); rtc_tick = 1'b0; step(2);
      end
      chk("R4 rtc reference", r_data, (r0 + 3) & 8'hFF);
      wr_ctrl(ctl(2, 0, 0, 0));

      // R5 event mode, rising then falling
      wr_ctrl(ctl(1, 1, 0, 0));
      step(2);
      c0 = data_rdata;
      ext_in = 1'b1; step(4);
      chk("R5 rising edge counted", data_rdata, (c0 + 1) & 8'hFF);
      ext_in = 1'b0; step(4);
      chk("R5 falling ignored", data_rdata, (c0 + 1) & 8'hFF);
      for (int i = 0; i < 5; i++) begin
         ext_in = 1'b1; step(3); ext_in = 1'b0; step(3);
      end
      step(4);
      chk("R5 pulse train", data_rdata, (c0 + 6) & 8'hFF);
      wr_ctrl(ctl(1, 1, 1, 0));
      c1 = data_rdata;
      ext_in = 1'b1; step(4);
      chk("R5 rising ignored", data_rdata, c1);
      ext_in = 1'b0; step(4);
      chk("R5 falling counted", data_rdata, (c1 + 1) & 8'hFF);

      // R9 pulse width, active high
      wr_ctrl(ctl(3, 0, 0, 0));
      c0 = data_rdata;
      wr_ctrl(ctl(3, 1, 0, 0));
      step(10);
      chk("R9 idle before edge", data_rdata, c0);
      ext_in = 1'b1; step(20);
      ext_in = 1'b0; step(6);
      chk("R9 width 20", data_rdata, (c0 + 10) & 8'hFF);
      chk("R9 enable cleared", ctrl_rdata[4], 0);
      ext_in = 1'b1; step(10); ext_in = 1'b0; step(6);
      chk("R9 stopped after clear", data_rdata, (c0 + 10) & 8'hFF);

      // R9 pulse width, active low
      c0 = data_rdata;
      wr_ctrl(ctl(3, 1, 1, 0));
      step(10);
      chk("R9 low level without edge", data_rdata, c0);
      ext_in = 1'b1; step(5);
      ext_in = 1'b0; step(15);
      ext_in = 1'b1; step(6);
      chk("R9 width 15 active low", data_rdata, (c0 + 7) & 8'hFF);
      chk("R9 enable cleared low", ctrl_rdata[4], 0);

      // R2 reload write leaves the live count alone
      wr_ctrl(ctl(2, 0, 0, 0));
      c0 = data_rdata;
      wr_data(8'h80);
      chk("R2 count after write", data_rdata, c0);
      step(3);
      chk("R2 count later", data_rdata, c0);

      // R6 wrap reload and sticky flag
      irq_clr = 1'b1; step(1); irq_clr = 1'b0;
      chk("R6 flag cleared", irq_flag, 0);
      wr_ctrl(ctl(2, 1, 0, 0));
      n = 0;
      while (!irq_flag && n < 2000) begin step(1); n++; end
      chk("R6 flag set", irq_flag, 1);
      chk("R6 reload value", data_rdata, 8'h80);
      step(20);
      chk("R6 flag sticky", irq_flag, 1);
      irq_clr = 1'b1; step(1); irq_clr = 1'b0;
      chk("R6 flag cleared by irq_clr", irq_flag, 0);

      // R7 square-wave half periods
      begin
         int nv [4] = '{8'h80, 8'hFC, 8'hF0, 8'h00};
         int pv [4] = '{0, 0, 1, 0};
         for (int i = 0; i < 4; i++) begin
            wr_data(8'(nv[i]));
            wr_ctrl(ctl(2, 1, 0, pv[i]));
            wait_pfd(n);
            wait_pfd(n);
            chk($sformatf("R7 half period N=%0d psc=%0d", nv[i], pv[i]),
                n, (256 - nv[i]) << (pv[i] + 1));
         end
      end

      finish_run();
   end
endmodule